// File: doc/BRIEF.md
# Magic-Constant Reciprocal Square Root Unit

This block returns an approximation of 1/sqrt(x) for a positive single-precision floating-point operand. The first estimate takes no table. The operand's bit pattern is read as an unsigned integer and moved right by one place. That value is then subtracted from a fixed constant. One Newton-Raphson step then refines the estimate. A shared single-precision multiplier and a single-precision subtractor carry out the step, and both round to nearest-even.

A caller pulses `start_i` with the operand on `x_i`. The block then runs one operation alone. It raises `done_o` for one cycle a fixed number of cycles later, with the result on `y_o`. A zero, negative or denormal operand sets `invalid_o` alongside `done_o`. The block uses it as a self-contained reciprocal-root primitive, for example in vector normalisation for lighting.

Top module: `rsqrt_magic`

## Requirements
- R1: The seed equals 0x5f3759df minus the operand bits, taken as an unsigned 32-bit integer and shifted right by one with a zero fill. The shift uses wiring only and takes no cycle.
- R2: The half operand decrements the exponent field (bits 30:23) by one. An exponent field of 0 or 1 produces zero.
- R3: The result is the single-precision value of 1.5*y0 − ((y0*y0)*y0)*xhalf. Each multiply and the final subtract rounds to nearest-even. For valid operands with exponent field 64..190, the result is positive and normal and bit-exact to that sequence.
- R4: An operand of 0x41800000 (16.0) yields 0x3e7f910e.
- R5: `done_o` is high exactly 12 rising edges after the edge that accepts `start_i`.
- R6: `done_o` is a single-cycle pulse for each accepted operation.
- R7: A `start_i` that arrives while an operation is in flight is ignored. It produces no extra result and does not disturb the one in flight.
- R8: `invalid_o` is 1 with `done_o` when the operand has sign bit 1 or exponent field 0, and 0 for positive normal operands.
- R9: After reset, `done_o`, `y_o` and `invalid_o` are all 0.
- R10: The block accepts a new `start_i` on the edge right after the one that raised `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts an operation when the block is idle |
| x_i | input | 32 | Single-precision operand |
| done_o | output | 1 | One-cycle result strobe |
| y_o | output | 32 | Single-precision result, held until the next result |
| invalid_o | output | 1 | Operand was zero, negative or denormal |

## Verification
Four properties are checked on every cycle:
- the one-cycle width of the done strobe;
- the fixed distance between acceptance and done, measured by a counter kept apart from the sequencer;
- the freeze of the captured operand while busy;
- the sign and normality of valid results.

Bit-exact numeric results come only from the bench's scenarios, which compare against an independently rounded reference. So do the single known value for 16.0, the flagging of bad operands, back-to-back acceptance and the dropping of overlapping starts.

// File: rtl/rsqrt_pkg.sv
package rsqrt_pkg;
  localparam int unsigned FW = 32;
  localparam int unsigned MW = 24;
  localparam int unsigned EXW = 10;
  localparam logic [7:0] BIAS = 8'd127;
  localparam logic [FW-1:0] THREE_HALVES = 32'h3fc00000;

  function automatic logic [FW-1:0] pack_rne(input logic s, input logic signed [EXW-1:0] e,
                                             input logic [MW-1:0] m, input logic g,
                                             input logic st);
    logic [MW:0] mr;
    logic signed [EXW-1:0] ef;
    mr = {1'b0, m} + {{MW{1'b0}}, (g & (st | m[0]))};
    ef = e;
    if (mr[MW]) ef = e + EXW'(1);
    return {s, ef[7:0], mr[MW-2:0]};
  endfunction
endpackage

// File: rtl/rsqrt_lzc.sv
module rsqrt_lzc #(
  parameter int unsigned W  = 27,
  localparam int unsigned OW = $clog2(W + 1)
) (
  input  logic [W-1:0]  a_i,
  output logic [OW-1:0] cnt_o
);
  always_comb begin
    cnt_o = OW'(W);
    for (int i = 0; i < W; i++) begin
      if (a_i[i]) cnt_o = OW'(W - 1 - i);
    end
  end
endmodule

// File: rtl/rsqrt_fmul.sv
module rsqrt_fmul
  import rsqrt_pkg::*;
(
  input  logic [FW-1:0] a_i,
  input  logic [FW-1:0] b_i,
  output logic [FW-1:0] y_o
);
  localparam int unsigned PW = 2 * MW;

  logic [MW-1:0] ma, mb;
  logic [PW-1:0] prod;
  logic signed [EXW-1:0] esum;
  logic [MW-1:0] mant;
  logic g, st;

  assign ma   = {1'b1, a_i[22:0]};
  assign mb   = {1'b1, b_i[22:0]};
  assign prod = ma * mb;
  assign esum = $signed(EXW'(a_i[30:23])) + $signed(EXW'(b_i[30:23])) - $signed(EXW'(BIAS));

  always_comb begin
    if (prod[PW-1]) begin
      mant = prod[PW-1 -: MW];
      g    = prod[PW-1-MW];
      st   = |prod[PW-2-MW:0];
    end else begin
      mant = prod[PW-2 -: MW];
      g    = prod[PW-2-MW];
      st   = |prod[PW-3-MW:0];
    end
    y_o = pack_rne(a_i[31] ^ b_i[31], esum + EXW'(prod[PW-1]), mant, g, st);
  end
endmodule

// File: rtl/rsqrt_fsub.sv
// a_i - b_i, caller guarantees a_i >= b_i > 0
module rsqrt_fsub
  import rsqrt_pkg::*;
(
  input  logic [FW-1:0] a_i,
  input  logic [FW-1:0] b_i,
  output logic [FW-1:0] y_o
);
  localparam int unsigned XW = MW + 3;
  localparam int unsigned SW = MW + XW;
  localparam int unsigned LW = $clog2(XW + 1);

  logic [7:0] d, dsh;
  logic [SW-1:0] sh;
  logic [XW-1:0] mb_x, diff, norm;
  logic [LW-1:0] lz;

  assign d    = a_i[30:23] - b_i[30:23];
  assign dsh  = (d > 8'(SW - 1)) ? 8'(SW - 1) : d;
  assign sh   = {1'b1, b_i[22:0], {XW{1'b0}}} >> dsh;
  assign mb_x = {sh[SW-1 -: XW-1], |sh[SW-XW:0]};
  assign diff = {1'b1, a_i[22:0], 3'b000} - mb_x;

  rsqrt_lzc #(.W(XW)) u_lzc (.a_i(diff), .cnt_o(lz));

  assign norm = diff << lz;
  assign y_o  = pack_rne(1'b0, $signed(EXW'(a_i[30:23])) - $signed(EXW'(lz)),
                         norm[XW-1 -: MW], norm[2], |norm[1:0]);
endmodule

// File: rtl/rsqrt_magic.sv
module rsqrt_magic
  import rsqrt_pkg::*;
#(
  parameter int unsigned LATENCY = 12,
  parameter logic [31:0] MAGIC   = 32'h5f3759df
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic [31:0] x_i,
  output logic        done_o,
  output logic [31:0] y_o,
  output logic        invalid_o
);
  // step schedule needs at least 7 cycles
  localparam int unsigned CW   = $clog2(LATENCY);
  localparam logic [CW-1:0] LAST = CW'(LATENCY - 1);

  logic          busy_q;
  logic [CW-1:0] cnt_q;
  logic [FW-1:0] x_q, y0_q, xh_q, acc_q, t_q, r_q, y_q;
  logic          inv_q, done_q, invalid_q;

  logic [FW-1:0] y0_d, xh_d, ma, mb, mul_y, sub_y;
  logic          inv_d;

  // seed: shift is pure wiring
  assign y0_d  = MAGIC - {1'b0, x_q[31:1]};
  assign xh_d  = (x_q[30:23] <= 8'd1) ? '0 : {x_q[31], x_q[30:23] - 8'd1, x_q[22:0]};
  assign inv_d = x_q[31] | (x_q[30:23] == 8'd0);

  always_comb begin
    case (cnt_q)
      CW'(2):  begin ma = acc_q; mb = y0_q;         end
      CW'(3):  begin ma = acc_q; mb = xh_q;         end
      CW'(4):  begin ma = y0_q;  mb = THREE_HALVES; end
      default: begin ma = y0_q;  mb = y0_q;         end
    endcase
  end

  rsqrt_fmul u_mul (.a_i(ma), .b_i(mb), .y_o(mul_y));
  rsqrt_fsub u_sub (.a_i(t_q), .b_i(acc_q), .y_o(sub_y));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0; cnt_q <= '0; x_q <= '0; y0_q <= '0; xh_q <= '0;
      acc_q <= '0; t_q <= '0; r_q <= '0; y_q <= '0; inv_q <= 1'b0;
      done_q <= 1'b0; invalid_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          x_q    <= x_i;
          busy_q <= 1'b1;
          cnt_q  <= '0;
        end
      end else begin
        cnt_q <= cnt_q + CW'(1);
        case (cnt_q)
          CW'(0): begin y0_q <= y0_d; xh_q <= xh_d; inv_q <= inv_d; end
          CW'(1), CW'(2), CW'(3): acc_q <= mul_y;
          CW'(4): t_q <= mul_y;
          CW'(5): r_q <= sub_y;
          default: ;
        endcase
        if (cnt_q == LAST) begin
          busy_q    <= 1'b0;
          done_q    <= 1'b1;
          y_q       <= r_q;
          invalid_q <= inv_q;
        end
      end
    end
  end

  assign done_o    = done_q;
  assign y_o       = y_q;
  assign invalid_o = invalid_q;

  // independent latency monitor
  logic [15:0] lat_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  lat_q <= 16'hffff;
    else if (!busy_q && start_i)  lat_q <= '0;
    else if (lat_q != 16'hffff)   lat_q <= lat_q + 16'd1;
  end

  a_r5_fixed_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> lat_q == 16'(LATENCY));
  a_r6_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r7_operand_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |=> $stable(x_q));
  a_r3_result_positive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !invalid_o) |-> (!y_o[31] && y_o[30:23] != 8'd0));
endmodule

// File: tb/sim_rsqrt_magic.sv
`timescale 1ns/1ps
module sim_rsqrt_magic;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [31:0] x = '0;
  logic done, inv;
  logic [31:0] y;

  always #4 clk = ~clk;

  rsqrt_magic u0 (.clk_i(clk), .rst_ni(rst_n), .start_i(start), .x_i(x),
                  .done_o(done), .y_o(y), .invalid_o(inv));

  typedef struct {
    logic [31:0] y;
    logic        inv;
    int          cyc;
    string       tag;
  } item_t;

  item_t q[$];
  int n_chk = 0, n_fail = 0, cyc = 0;
  logic prev_done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic real s2r(input logic [31:0] b);
    if (b[30:23] == 0) return 0.0;
    return $bitstoreal({b[31], 11'(int'(b[30:23]) - 127 + 1023), b[22:0], 29'b0});
  endfunction

  function automatic logic [31:0] r2s(input real v);
    logic [63:0] d;
    int e;
    logic [23:0] m;
    d = $realtobits(v);
    e = int'(d[62:52]) - 1023 + 127;
    m = {1'b0, d[51:29]} + 24'(d[28] & ((|d[27:0]) | d[29]));
    if (m[23]) e++;
    return {d[63], 8'(e), m[22:0]};
  endfunction

  function automatic logic [31:0] ref_rsqrt(input logic [31:0] xv);
    logic [31:0] y0, xh, p;
    y0 = 32'h5f3759df - {1'b0, xv[31:1]};
    xh = (xv[30:23] <= 1) ? 32'h0 : {xv[31], xv[30:23] - 8'd1, xv[22:0]};
    p  = r2s(s2r(y0) * s2r(y0));
    p  = r2s(s2r(p) * s2r(y0));
    p  = r2s(s2r(p) * s2r(xh));
    return r2s(s2r(r2s(s2r(y0) * 1.5)) - s2r(p));
  endfunction

  task automatic send(input logic [31:0] xv, input string tag, input bit fixed, input logic [31:0] fy);
    item_t it;
    do begin @(negedge clk); #1; end while (q.size() != 0);
    start = 1'b1; x = xv;
    @(posedge clk); #1;
    start = 1'b0;
    it.inv = xv[31] | (xv[30:23] == 0);
    it.y   = fixed ? fy : ref_rsqrt(xv);
    it.cyc = cyc;
    it.tag = tag;
    q.push_back(it);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (done) begin
        check(!prev_done, "R6 strobe width", 32'(prev_done), 32'd0);
        if (q.size() == 0) begin
          check(1'b0, "R7 unexpected result", y, 32'h0);
        end else begin
          item_t it;
          it = q.pop_front();
          check(cyc - it.cyc == 12, {it.tag, " R5 latency"}, 32'(cyc - it.cyc), 32'd12);
          check(inv == it.inv, {it.tag, " R8 invalid"}, 32'(inv), 32'(it.inv));
          if (!it.inv) check(y == it.y, {it.tag, " value"}, y, it.y);
        end
      end
      prev_done = done;
    end
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    check(1'b0, "watchdog", 32'h0, 32'h0);
    finish_run();
  end

  initial begin
    logic [31:0] lfsr;
    repeat (3) @(posedge clk);
    #1;
    check(done == 1'b0 && y == 32'h0 && inv == 1'b0, "R9 reset state", {y[31:1], done}, 32'h0);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);

    send(32'h41800000, "R4 sixteen", 1'b1, 32'h3e7f910e);
    send(32'h3f800000, "R1 R3 one", 1'b0, 0);
    send(32'h40800000, "R1 R3 four", 1'b0, 0);
    send(32'h40000000, "R2 R3 odd exponent", 1'b0, 0);
    send(32'h3c23d70a, "R3 small", 1'b0, 0);
    send(32'h42c80000, "R3 hundred", 1'b0, 0);
    send(32'h2f000000, "R3 low range", 1'b0, 0);
    send(32'h5e800000, "R3 high range", 1'b0, 0);

    // R10: sends below are issued on the done cycle
    lfsr = 32'hace1_2b57;
    for (int i = 0; i < 20; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      send({1'b0, 8'(100 + (lfsr[30:23] % 61)), lfsr[22:0]}, "R1 R2 R3 R10 sweep", 1'b0, 0);
    end

    send(32'hc0800000, "R8 negative", 1'b0, 0);
    send(32'h00000000, "R8 zero", 1'b0, 0);
    send(32'h00000123, "R8 denormal", 1'b0, 0);

    // R7: overlapping starts while busy
    send(32'h40400000, "R7 first operand", 1'b0, 0);
    repeat (2) @(negedge clk);
    start = 1'b1; x = 32'h3e800000;
    repeat (5) @(negedge clk);
    start = 1'b0;
    repeat (30) @(negedge clk);
    check(q.size() == 0, "R7 pending after overlap", 32'(q.size()), 32'd0);

    // R10: explicit back-to-back spacing
    send(32'h41100000, "R10 first", 1'b0, 0);
    send(32'h41c80000, "R10 second", 1'b0, 0);
    repeat (20) @(negedge clk);
    check(q.size() == 0, "R10 drained", 32'(q.size()), 32'd0);
    finish_run();
  end
endmodule